// File: doc/BRIEF.md
# Two-Word Read Instruction Intake Sequencer

This block collects a read instruction from a host, one 30-bit word at a time. It asks for a word by holding `in_ready` high. The host answers by raising `in_valid` with the word on `in_word`, and the word is taken on the clock edge where both are high. The sequencer then lowers `in_ready` for one check cycle and classifies the 6-bit instruction code in the word. It then does one of four things: it asks for the next word, it returns to the first slot, it raises an error interrupt, or it tells the drum read path where to begin searching.

The two-word ordering is enforced. The first slot must hold the first word of a read. A read second-word code arriving there is a sequential error. The second slot must hold the read second word, a master clear or a read/write terminate. Any other code there is a combinational error. Once a complete instruction is held, the begin address is checked against the drum capacity `DRUM_WORDS`. A valid address produces a one-cycle `search_start` strobe with `search_addr`.

Back-pressure follows valid/ready rules. The host keeps `in_word` stable while `in_valid` is high and `in_ready` is low. The interrupt port is also valid/ready: `irq_code` stays fixed while `irq_valid` is high, until the host raises `irq_ready`. `search_start` and `read_abort` are plain control strobes with no handshake.

Top module: `instr_intake_seq`

## Requirements
- R1: After reset, `in_ready` is 1 and `irq_valid`, `search_start` and `read_abort` are 0.
- R2: In the cycle after a word is taken (`in_valid` and `in_ready` both high at a clock edge), `in_ready` is 0. A word held on `in_valid` during that check cycle is not taken a second time.
- R3: A first-slot word whose code field `in_word[29:24]` equals 6'h11 (read second word) raises `irq_valid` with `irq_code` = 1 (sequential error), one cycle after the check cycle.
- R4: A first-slot word with code 6'h10 (read first word) causes `in_ready` to return to 1 right after the check cycle, which opens the second slot.
- R5: In the second slot, any code other than 6'h11, 6'h3F (master clear) or 6'h3E (terminate) raises `irq_code` = 2 (combinational error). Examples are 6'h10 and 6'h20 (write first word).
- R6: A second-slot 6'h11 word whose begin address `in_word[19:0]` is at or above `DRUM_WORDS` raises `irq_code` = 3 (address error), and `search_start` stays 0.
- R7: A second-slot 6'h11 word with address below `DRUM_WORDS` gives a one-cycle `search_start` with `search_addr` equal to that address. The sequencer then returns to the first slot with no interrupt.
- R8: Code 6'h3F in either slot gives a one-cycle `read_abort`, raises no interrupt, and returns the sequencer to the first slot.
- R9: Code 6'h3E in the second slot gives a one-cycle `read_abort`, raises no interrupt, and returns the sequencer to the first slot.
- R10: `irq_valid` and `irq_code` hold steady, and `in_ready` stays 0, until `irq_ready` is seen. In the next cycle `irq_valid` is 0 and `in_ready` is 1, with the sequencer in the first slot.
- R11: A first-slot word with any code other than 6'h10, 6'h11 or 6'h3F (for example 6'h20 or 6'h3E) is discarded. It raises no interrupt, start or abort, and the sequencer stays in the first slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host presents an instruction word |
| in_ready | output | 1 | Sequencer requests a word |
| in_word | input | 30 | Instruction word: code in [29:24], address in [19:0] |
| irq_valid | output | 1 | Error interrupt pending |
| irq_ready | input | 1 | Host accepts the interrupt |
| irq_code | output | 2 | 1 sequential, 2 combinational, 3 address error |
| search_start | output | 1 | One-cycle command to begin the drum search |
| search_addr | output | 20 | Begin address sent with `search_start` |
| read_abort | output | 1 | One-cycle abort to the read engine |

## Verification
The assertions check properties that must hold on every cycle. The request line drops after each accepted word. The start and abort strobes last one cycle and never coincide with each other or with a pending interrupt. A pending interrupt holds its code and blocks new words. Every issued address lies below the drum capacity. Only the bench scenarios can show that the correct interrupt code goes with each slot and code combination, including the address just at and just below the limit. They also show that master clear and terminate act differently in each slot, that discarded first-slot codes leave the slot unchanged, and that a word held through the check cycle is not taken twice.

// File: rtl/instr_intake_pkg.sv
package instr_intake_pkg;
  typedef enum logic [2:0] {
    ST_REQ1,
    ST_CHK1,
    ST_REQ2,
    ST_CHK2,
    ST_IRQ
  } seq_state_e;

  typedef enum logic [2:0] {
    CL_RD1,
    CL_RD2,
    CL_MCLR,
    CL_TERM,
    CL_OTHER
  } code_class_e;

  typedef enum logic [1:0] {
    IRQ_NONE = 2'd0,
    IRQ_SEQ  = 2'd1,
    IRQ_COMB = 2'd2,
    IRQ_ADDR = 2'd3
  } irq_code_e;
endpackage

// File: rtl/intake_code_decode.sv
module intake_code_decode
  import instr_intake_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter logic [CODE_W-1:0] CODE_RD1  = 6'h10,
  parameter logic [CODE_W-1:0] CODE_RD2  = 6'h11,
  parameter logic [CODE_W-1:0] CODE_MCLR = 6'h3F,
  parameter logic [CODE_W-1:0] CODE_TERM = 6'h3E
) (
  input  logic [CODE_W-1:0] code,
  output code_class_e       cls
);
  always_comb begin
    if (code == CODE_MCLR)      cls = CL_MCLR;
    else if (code == CODE_RD1)  cls = CL_RD1;
    else if (code == CODE_RD2)  cls = CL_RD2;
    else if (code == CODE_TERM) cls = CL_TERM;
    else                        cls = CL_OTHER;
  end
endmodule

// File: rtl/intake_addr_check.sv
module intake_addr_check #(
  parameter int ADDR_W     = 20,
  parameter int DRUM_WORDS = 786432
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              addr_ok
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DRUM_WORDS);

  always_comb addr_ok = ({1'b0, addr} < LIMIT);
endmodule

// File: rtl/instr_intake_seq.sv
module instr_intake_seq
  import instr_intake_pkg::*;
#(
  parameter int WORD_W     = 30,
  parameter int CODE_W     = 6,
  parameter int ADDR_W     = 20,
  parameter int DRUM_WORDS = 786432,
  parameter logic [CODE_W-1:0] CODE_RD1  = 6'h10,
  parameter logic [CODE_W-1:0] CODE_RD2  = 6'h11,
  parameter logic [CODE_W-1:0] CODE_MCLR = 6'h3F,
  parameter logic [CODE_W-1:0] CODE_TERM = 6'h3E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [1:0]        irq_code,
  output logic              search_start,
  output logic [ADDR_W-1:0] search_addr,
  output logic              read_abort
);
  localparam int CODE_LSB = WORD_W - CODE_W;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DRUM_WORDS);

  seq_state_e        state_q, state_d;
  logic [WORD_W-1:0] word_q;
  irq_code_e         irq_q, irq_d;
  logic              start_q, start_d;
  logic              abort_q, abort_d;
  logic [ADDR_W-1:0] addr_q;
  code_class_e       cls;
  logic              addr_ok;
  logic              accept;

  assign accept = in_valid && in_ready;

  intake_code_decode #(
    .CODE_W(CODE_W), .CODE_RD1(CODE_RD1), .CODE_RD2(CODE_RD2),
    .CODE_MCLR(CODE_MCLR), .CODE_TERM(CODE_TERM)
  ) dec_i (
    .code(word_q[WORD_W-1:CODE_LSB]),
    .cls (cls)
  );

  intake_addr_check #(.ADDR_W(ADDR_W), .DRUM_WORDS(DRUM_WORDS)) chk_i (
    .addr   (word_q[ADDR_W-1:0]),
    .addr_ok(addr_ok)
  );

  always_comb begin
    state_d = state_q;
    irq_d   = irq_q;
    start_d = 1'b0;
    abort_d = 1'b0;
    unique case (state_q)
      ST_REQ1: if (accept) state_d = ST_CHK1;
      ST_REQ2: if (accept) state_d = ST_CHK2;
      ST_CHK1: begin
        unique case (cls)
          CL_RD1:  state_d = ST_REQ2;
          CL_RD2:  begin state_d = ST_IRQ; irq_d = IRQ_SEQ; end
          CL_MCLR: begin state_d = ST_REQ1; abort_d = 1'b1; end
          default: state_d = ST_REQ1;
        endcase
      end
      ST_CHK2: begin
        unique case (cls)
          CL_RD2: begin
            if (addr_ok) begin
              state_d = ST_REQ1;
              start_d = 1'b1;
            end else begin
              state_d = ST_IRQ;
              irq_d   = IRQ_ADDR;
            end
          end
          CL_MCLR, CL_TERM: begin state_d = ST_REQ1; abort_d = 1'b1; end
          default: begin state_d = ST_IRQ; irq_d = IRQ_COMB; end
        endcase
      end
      ST_IRQ: if (irq_ready) begin
        state_d = ST_REQ1;
        irq_d   = IRQ_NONE;
      end
      default: state_d = ST_REQ1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_REQ1;
      word_q  <= '0;
      irq_q   <= IRQ_NONE;
      start_q <= 1'b0;
      abort_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
      start_q <= start_d;
      abort_q <= abort_d;
      if (accept) word_q <= in_word;
      if (start_d) addr_q <= word_q[ADDR_W-1:0];
    end
  end

  assign in_ready     = (state_q == ST_REQ1) || (state_q == ST_REQ2);
  assign irq_valid    = (state_q == ST_IRQ);
  assign irq_code     = irq_q;
  assign search_start = start_q;
  assign search_addr  = addr_q;
  assign read_abort   = abort_q;

  // R2
  ready_drops_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R7
  start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    search_start |=> !search_start);
  // R8
  abort_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_abort |=> !read_abort);
  // R6
  start_addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    search_start |-> ({1'b0, search_addr} < LIMIT));
  // R6
  start_excl_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(search_start && (irq_valid || read_abort)));
  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> (irq_valid && $stable(irq_code)));
  // R10
  irq_blocks_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !in_ready);
  // R10
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> (!irq_valid && in_ready));
endmodule

// File: tb/instr_intake_seq_tb_top.sv
module instr_intake_seq_tb_top;
  localparam int AW = 20;
  localparam int DRUM = 786432;
  localparam logic [5:0] RD1 = 6'h10, RD2 = 6'h11, WR1 = 6'h20,
                         TERM = 6'h3E, MCLR = 6'h3F;

  typedef struct packed {
    logic [1:0]    kind;   // 0 start, 1 abort, 2 irq
    logic [AW-1:0] val;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [29:0] in_word = '0;
  logic irq_ready = 1'b0;
  logic in_ready, irq_valid, search_start, read_abort;
  logic [1:0] irq_code;
  logic [AW-1:0] search_addr;

  int checks = 0;
  int failures = 0;
  ev_t exp_q[$];
  logic irq_prev = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  instr_intake_seq dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_code(irq_code), .search_start(search_start),
    .search_addr(search_addr), .read_abort(read_abort)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [29:0] mk(input logic [5:0] c, input int a);
    return {c, 4'b0, AW'(a)};
  endfunction

  task automatic expect_ev(input logic [1:0] k, input int v);
    ev_t e;
    e.kind = k;
    e.val  = AW'(v);
    exp_q.push_back(e);
  endtask

  // Monitor: compare observed events against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n) begin
      ev_t obs;
      bit seen;
      seen = 1'b0;
      obs  = '0;
      if (search_start) begin obs.kind = 2'd0; obs.val = search_addr; seen = 1'b1; end
      else if (read_abort) begin obs.kind = 2'd1; seen = 1'b1; end
      else if (irq_valid && !irq_prev) begin obs.kind = 2'd2; obs.val = AW'(irq_code); seen = 1'b1; end
      if (seen) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected event", int'(obs.kind), -1);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(e == obs, (e.kind == 2'd0) ? "R7 start" : (e.kind == 2'd1) ? "R8/R9 abort" : "R3/R5/R6 irq",
              int'(obs.kind) * 1000000 + int'(obs.val), int'(e.kind) * 1000000 + int'(e.val));
        end
      end
      irq_prev <= irq_valid;
    end
  end

  task automatic send(input logic [29:0] w, input bit hold_extra);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    chk(!in_ready, "R2 ready low in check cycle", int'(in_ready), 0);
    if (hold_extra) @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic ack_irq(input int code);
    while (!irq_valid) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(irq_valid && !in_ready && irq_code == 2'(code), "R10 irq held, words blocked",
        int'(irq_code), code);
    irq_ready = 1'b1;
    @(negedge clk);
    irq_ready = 1'b0;
    chk(!irq_valid && in_ready, "R10 release after ack", int'(irq_valid), 0);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(in_ready && !irq_valid && !search_start && !read_abort, "R1 reset state",
        int'(in_ready), 1);

    // R4, R7: normal read
    send(mk(RD1, 0), 1'b0);
    @(negedge clk);
    chk(in_ready, "R4 second slot requested", int'(in_ready), 1);
    expect_ev(2'd0, 100);
    send(mk(RD2, 100), 1'b0);
    settle();

    // R3: second word first
    expect_ev(2'd2, 1);
    send(mk(RD2, 5), 1'b0);
    ack_irq(1);

    // R5: write code and repeated first word in second slot
    send(mk(RD1, 0), 1'b0);
    expect_ev(2'd2, 2);
    send(mk(WR1, 7), 1'b0);
    ack_irq(2);
    send(mk(RD1, 0), 1'b0);
    expect_ev(2'd2, 2);
    send(mk(RD1, 0), 1'b0);
    ack_irq(2);

    // R6: address at capacity; R7: address just below
    send(mk(RD1, 0), 1'b0);
    expect_ev(2'd2, 3);
    send(mk(RD2, DRUM), 1'b0);
    ack_irq(3);
    send(mk(RD1, 0), 1'b0);
    expect_ev(2'd0, DRUM - 1);
    send(mk(RD2, DRUM - 1), 1'b0);
    settle();

    // R8: master clear in second slot, then slot is first again
    send(mk(RD1, 0), 1'b0);
    expect_ev(2'd1, 0);
    send(mk(MCLR, 0), 1'b0);
    settle();
    expect_ev(2'd2, 1);
    send(mk(RD2, 3), 1'b0);
    ack_irq(1);
    // R8: master clear in first slot
    expect_ev(2'd1, 0);
    send(mk(MCLR, 0), 1'b0);
    settle();

    // R9: terminate in second slot
    send(mk(RD1, 0), 1'b0);
    expect_ev(2'd1, 0);
    send(mk(TERM, 0), 1'b0);
    settle();
    chk(in_ready && !irq_valid, "R9 back to idle without irq", int'(irq_valid), 0);

    // R11: write and terminate codes discarded in first slot
    send(mk(WR1, 9), 1'b0);
    send(mk(TERM, 0), 1'b0);
    settle();
    chk(in_ready && !irq_valid, "R11 no reaction to discarded codes", int'(irq_valid), 0);
    expect_ev(2'd2, 1);
    send(mk(RD2, 1), 1'b0);
    ack_irq(1);

    // R2: word held through check cycle is not taken twice
    send(mk(RD1, 0), 1'b1);
    expect_ev(2'd0, 42);
    send(mk(RD2, 42), 1'b0);
    settle();

    chk(exp_q.size() == 0, "R7 all expected events seen", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule